// File: doc/BRIEF.md
# Dual Block Error Counters with Threshold Alarms

This block keeps two saturating 8-bit tallies of transmission block errors, fed by one-cycle error strobes that arrive once per superframe: a near-end strobe (the local check on received data failed) and a far-end strobe (the remote end reported a failure). Tally A counts near-end errors only, or near-end and far-end errors together, as chosen by a mode input. Tally B always counts far-end errors.

Each tally has its own host-writable 8-bit limit. When an error pushes a tally to or past its limit, the block raises a one-cycle queue request that carries the tally's value, for an interrupt stack outside the block. The request is an early alarm that transmission is degrading. A small register interface with read and write strobes lets software set the limits, read the tallies and force a tally into the queue. Reading a tally clears it.

Register map (3-bit address): 0 = tally A (read clears), 1 = tally B (read clears), 2 = limit A, 3 = limit B, 4 = queue command (write only). Any other address reads as 0.

Top module: `blkerr_monitor`

## Requirements
- R1: After reset both tallies read 0x00, both limits read 0xFF, and `q_req` is 2'b00.
- R2: With `combine_mode` = 1, tally A adds 1 for each of `ne_err` and `fe_err` that is high in a cycle, so it adds 2 when both are high.
- R3: With `combine_mode` = 0, tally A counts `ne_err` only and ignores `fe_err`.
- R4: Tally B adds 1 for each cycle in which `fe_err` is high, whatever the value of `combine_mode`.
- R5: A tally saturates at 0xFF and never wraps to a lower value.
- R6: A read strobe at address 0 or 1 places the tally's value on `host_rdata` in the cycle after the strobe and clears the tally to 0. `host_rdata` holds its value until the next read.
- R7: If an error arrives in the same cycle as a read of its tally, the read returns the old value and the tally then holds that cycle's increment.
- R8: A write at address 2 or 3 loads `host_wdata` into limit A or B. A read at the same address returns the limit in the cycle after the strobe.
- R9: When an increment makes a tally equal to or greater than its limit, bit 0 (tally A) or bit 1 (tally B) of `q_req` is high for exactly one cycle, in the same cycle the new value appears. The matching byte of `q_data` (bits 7:0 for A, bits 15:8 for B) then holds that value. The alarm does not fire again until the tally has been cleared by a read.
- R10: A write at address 4 with `host_wdata` bit 0 and/or bit 1 set raises the matching `q_req` bit in the next cycle, with the current tally on `q_data`. The command does not persist: `q_req` drops one cycle later with no further write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| combine_mode | input | 1 | 1: tally A counts near-end plus far-end errors; 0: near-end only |
| ne_err | input | 1 | Near-end block error strobe |
| fe_err | input | 1 | Far-end block error strobe |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, registered |
| q_req | output | 2 | Queue request per tally, one-cycle pulse |
| q_data | output | 16 | Tally value carried with each request; A in 7:0, B in 15:8 |

## Verification
The bench builds the block with its default parameters: 8-bit tallies, two counters and a 3-bit address. At that width an unbroken run of combined double errors drives tally A from a low value into saturation in about 130 cycles, so the bench reaches both the 0xFF clamp and the single threshold firing at the limit's reset value within a short run. Small programmed limits such as 3 make it possible to check crossing the limit with a step of 2, the one-shot behaviour and re-arming after a read within a few cycles.

// File: rtl/blkerr_pkg.sv
package blkerr_pkg;
    localparam int unsigned CNT_W    = 8;
    localparam int unsigned NUM_CNT  = 2;
    localparam int unsigned ADDR_W   = 3;
    // address map: tallies first, then limits, then the queue command
    localparam int unsigned ADR_CNT_BASE = 0;
    localparam int unsigned ADR_THR_BASE = ADR_CNT_BASE + NUM_CNT;
    localparam int unsigned ADR_QCMD     = ADR_THR_BASE + NUM_CNT;
endpackage

// File: rtl/blkerr_counter.sv
module blkerr_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   inc,
    input  logic         clr,
    input  logic         fq,
    input  logic [W-1:0] thr,
    output logic [W-1:0] cnt,
    output logic         req,
    output logic [W-1:0] qdata
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         armed;
        logic         req;
        logic [W-1:0] qdata;
    } st_t;

    st_t st_d, st_q;

    logic [W-1:0] base_c;
    logic [W:0]   sum_c;
    logic [W-1:0] sat_c;
    logic         armed_c;
    logic         hit_c;

    always_comb begin
        // a read clears first; the same cycle's increment lands on zero
        base_c  = clr ? '0 : st_q.cnt;
        sum_c   = {1'b0, base_c} + (W+1)'(inc);
        sat_c   = sum_c[W] ? CNT_MAX : sum_c[W-1:0];
        armed_c = st_q.armed | clr;
        hit_c   = (inc != 2'd0) && armed_c && (sat_c >= thr);

        st_d       = st_q;
        st_d.cnt   = sat_c;
        st_d.armed = armed_c & ~hit_c;
        st_d.req   = hit_c | fq;
        if (hit_c || fq) begin
            st_d.qdata = sat_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.armed <= 1'b1;
            st_q.req   <= 1'b0;
            st_q.qdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt   = st_q.cnt;
    assign req   = st_q.req;
    assign qdata = st_q.qdata;

    // R2: without a clear the tally never steps by more than two
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (st_q.cnt - $past(st_q.cnt)) <= W'(2));

    // R5: without a clear the tally never falls, so it cannot wrap
    p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> st_q.cnt >= $past(st_q.cnt));

    // R6: a read with no error in that cycle leaves the tally at zero
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && inc == 2'd0) |=> st_q.cnt == '0);

    // R9: an alarm not caused by a command carries a value at or above the limit
    p_alarm_thr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.req && !$past(fq)) |-> st_q.qdata >= $past(thr));

    // R10: a queue command always yields a request in the next cycle
    p_force_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fq |=> st_q.req);
endmodule

// File: rtl/blkerr_thresholds.sv
module blkerr_thresholds #(
    parameter int unsigned W      = 8,
    parameter int unsigned N      = 2,
    parameter int unsigned AW     = 3,
    parameter int unsigned BASE   = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr,
    input  logic [AW-1:0]  addr,
    input  logic [W-1:0]   wdata,
    output logic [N*W-1:0] thr
);
    typedef struct packed {
        logic [N-1:0][W-1:0] lim;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (wr && addr == AW'(BASE + i)) begin
                st_d.lim[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.lim <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign thr = st_q.lim;

    // R8: limits change only through a write strobe
    p_thr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(st_q.lim));
endmodule

// File: rtl/blkerr_monitor.sv
module blkerr_monitor
    import blkerr_pkg::*;
#(
    parameter int unsigned W = CNT_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  combine_mode,
    input  logic                  ne_err,
    input  logic                  fe_err,
    input  logic                  host_wr,
    input  logic                  host_rd,
    input  logic [ADDR_W-1:0]     host_addr,
    input  logic [W-1:0]          host_wdata,
    output logic [W-1:0]          host_rdata,
    output logic [NUM_CNT-1:0]    q_req,
    output logic [NUM_CNT*W-1:0]  q_data
);
    localparam logic [ADDR_W-1:0] A_QCMD = ADDR_W'(ADR_QCMD);

    logic [NUM_CNT-1:0][W-1:0] cnt_w;
    logic [NUM_CNT*W-1:0]      thr_w;
    logic [NUM_CNT-1:0]        clr_w;
    logic [NUM_CNT-1:0]        fq_w;

    blkerr_thresholds #(
        .W(W), .N(NUM_CNT), .AW(ADDR_W), .BASE(ADR_THR_BASE)
    ) u_thr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (host_wr),
        .addr  (host_addr),
        .wdata (host_wdata),
        .thr   (thr_w)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        logic [1:0] inc;
        if (g == 0) begin : g_mix
            assign inc = {1'b0, ne_err} + {1'b0, fe_err & combine_mode};
        end else begin : g_far
            assign inc = {1'b0, fe_err};
        end
        assign clr_w[g] = host_rd && (host_addr == ADDR_W'(ADR_CNT_BASE + g));
        assign fq_w[g]  = host_wr && (host_addr == A_QCMD) && host_wdata[g];

        blkerr_counter #(.W(W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc),
            .clr   (clr_w[g]),
            .fq    (fq_w[g]),
            .thr   (thr_w[g*W +: W]),
            .cnt   (cnt_w[g]),
            .req   (q_req[g]),
            .qdata (q_data[g*W +: W])
        );
    end

    typedef struct packed {
        logic [W-1:0] rdata;
    } rd_st_t;

    rd_st_t rd_d, rd_q;
    logic [W-1:0] sel_c;

    always_comb begin
        sel_c = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (host_addr == ADDR_W'(ADR_CNT_BASE + i)) sel_c = cnt_w[i];
            if (host_addr == ADDR_W'(ADR_THR_BASE + i)) sel_c = thr_w[i*W +: W];
        end
        rd_d = rd_q;
        if (host_rd) begin
            rd_d.rdata = sel_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q.rdata <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign host_rdata = rd_q.rdata;

    // R6: read data holds between read strobes
    p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_rdata));

    // R1: no request can be pending in the first cycle after reset
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> q_req == '0);
endmodule

// File: tb/sim_blkerr_monitor.sv
`timescale 1ns/1ps
module sim_blkerr_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        combine_mode = 1'b0;
    logic        ne_err = 1'b0;
    logic        fe_err = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [1:0]  q_req;
    logic [15:0] q_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    blkerr_monitor u0 (
        .clk(clk), .rst_n(rst_n), .combine_mode(combine_mode),
        .ne_err(ne_err), .fe_err(fe_err), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .q_req(q_req), .q_data(q_data)
    );

    typedef struct packed {
        logic       mode, ne, fe, rd, wr;
        logic [2:0] addr;
        logic [7:0] wdata;
        logic       chk_rd;
        logic [7:0] exp_rd;
        logic [1:0] exp_req;
        logic [7:0] exp_qa, exp_qb;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        '{1,1,1,0,0,3'd0,8'h00,0,8'h00,2'b00,8'h00,8'h00,4'd2},  // R2 A=2 B=1
        '{1,1,0,0,0,3'd0,8'h00,0,8'h00,2'b00,8'h00,8'h00,4'd2},  // R2 A=3
        '{0,1,1,0,0,3'd0,8'h00,0,8'h00,2'b00,8'h00,8'h00,4'd3},  // R3 A=4 B=2
        '{0,0,1,0,0,3'd0,8'h00,0,8'h00,2'b00,8'h00,8'h00,4'd4},  // R4 B=3
        '{0,0,0,1,0,3'd0,8'h00,1,8'h04,2'b00,8'h00,8'h00,4'd6},  // R6 read A
        '{0,0,0,1,0,3'd1,8'h00,1,8'h03,2'b00,8'h00,8'h00,4'd4},  // R4 read B
        '{0,1,0,0,0,3'd0,8'h00,0,8'h00,2'b00,8'h00,8'h00,4'd3},  // R3 A=1
        '{1,1,1,1,0,3'd0,8'h00,1,8'h01,2'b00,8'h00,8'h00,4'd7},  // R7 old value
        '{1,0,0,1,0,3'd0,8'h00,1,8'h02,2'b00,8'h00,8'h00,4'd7},  // R7 increment kept
        '{1,0,0,1,0,3'd1,8'h00,1,8'h01,2'b00,8'h00,8'h00,4'd4},  // R4 B=1
        '{1,0,0,0,1,3'd2,8'h03,0,8'h00,2'b00,8'h00,8'h00,4'd8},  // R8 limit A=3
        '{1,0,0,1,0,3'd2,8'h00,1,8'h03,2'b00,8'h00,8'h00,4'd8},  // R8 readback
        '{1,1,0,0,0,3'd0,8'h00,0,8'h00,2'b00,8'h00,8'h00,4'd9},  // R9 A=1 below
        '{1,1,1,0,0,3'd0,8'h00,0,8'h00,2'b01,8'h03,8'h00,4'd9},  // R9 A=3 fires
        '{0,1,0,0,0,3'd0,8'h00,0,8'h00,2'b00,8'h00,8'h00,4'd9},  // R9 no refire
        '{0,0,0,1,0,3'd0,8'h00,1,8'h04,2'b00,8'h00,8'h00,4'd6},  // R6 clear, rearm
        '{0,1,0,0,0,3'd0,8'h00,0,8'h00,2'b00,8'h00,8'h00,4'd9},  // R9 A=1 below
        '{0,0,0,0,1,3'd4,8'h03,0,8'h00,2'b11,8'h01,8'h01,4'd10}, // R10 force both
        '{0,0,0,0,0,3'd0,8'h00,0,8'h00,2'b00,8'h00,8'h00,4'd10}  // R10 self-clear
    };

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, let one rising edge pass, return at the next falling edge
    task automatic step(input logic m, input logic ne, input logic fe,
                        input logic rd, input logic wr,
                        input logic [2:0] a, input logic [7:0] d);
        combine_mode = m; ne_err = ne; fe_err = fe;
        host_rd = rd; host_wr = wr; host_addr = a; host_wdata = d;
        @(posedge clk);
        @(negedge clk);
        ne_err = 0; fe_err = 0; host_rd = 0; host_wr = 0;
    endtask

    initial begin
        int pulses_a;
        int pulses_b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 q_req after reset", q_req, 0);
        step(0,0,0,1,0,3'd2,0); check("R1 limit A", host_rdata, 8'hFF);
        step(0,0,0,1,0,3'd3,0); check("R1 limit B", host_rdata, 8'hFF);
        step(0,0,0,1,0,3'd0,0); check("R1 tally A", host_rdata, 0);
        step(0,0,0,1,0,3'd1,0); check("R1 tally B", host_rdata, 0);

        for (int i = 0; i < NV; i++) begin
            string t;
            step(TBL[i].mode, TBL[i].ne, TBL[i].fe, TBL[i].rd, TBL[i].wr,
                 TBL[i].addr, TBL[i].wdata);
            t = $sformatf("R%0d row %0d", TBL[i].rq, i);
            check({t, " q_req"}, q_req, TBL[i].exp_req);
            if (TBL[i].chk_rd) check({t, " rdata"}, host_rdata, TBL[i].exp_rd);
            if (TBL[i].exp_req[0]) check({t, " q_data A"}, q_data[7:0], TBL[i].exp_qa);
            if (TBL[i].exp_req[1]) check({t, " q_data B"}, q_data[15:8], TBL[i].exp_qb);
        end

        // R5 and R9: limit A back to 0xFF, then double errors past saturation
        step(1,0,0,0,1,3'd2,8'hFF);
        pulses_a = 0;
        pulses_b = 0;
        for (int k = 0; k < 140; k++) begin
            step(1,1,1,0,0,3'd0,0);
            if (q_req[0]) begin
                pulses_a++;
                check("R9 alarm value at saturation", q_data[7:0], 8'hFF);
            end
            if (q_req[1]) pulses_b++;
        end
        check("R9 single alarm for tally A", pulses_a, 1);
        check("R9 no alarm for tally B below limit", pulses_b, 0);
        step(1,0,0,1,0,3'd0,0); check("R5 tally A saturated", host_rdata, 8'hFF);
        step(1,0,0,1,0,3'd1,0); check("R4 tally B after run", host_rdata, 8'h8D);
        step(1,0,0,1,0,3'd5,0); check("R6 unmapped address reads 0", host_rdata, 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule